// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block connects two byte-wide bidirectional ports, A and B, through two independent storage banks. One bank takes data from A and presents it on B, and the other takes data from B and presents it on A. Each direction has three active-low controls. A select qualifies everything in that direction. A capture control makes the bank follow its source port. A drive control lets the bank's contents appear on the far port.

The core is synchronous to `clk`, so that it can be synthesized without internal tri-states. Each port is split into an input vector, an output vector and an output-enable flag. The pad-level tri-state buffers belong to the chip's I/O ring. While a direction is selected and capturing, its bank reloads from the source port at every clock edge, which is the clocked form of "transparent". Raising the capture control freezes the value taken at the last edge. Both output enables are registered. A contention flag warns when both directions drive at the same time.

Top module: `bilatch_xcvr`

## Requirements
- R1: While `rst_n` is low at a clock edge, both banks clear to zero. After that edge `a_oe`, `b_oe` and `contention` are 0 and `a_out`, `b_out` are all zeros.
- R2: At a clock edge where `sel_ab_n`=0 and `cap_ab_n`=0, the A-to-B bank loads `a_in`.
- R3: At a clock edge where `cap_ab_n`=1, the A-to-B bank keeps its value, so later changes on `a_in` do not reach `b_out`.
- R4: At a clock edge where `sel_ab_n`=1, the A-to-B bank keeps its value whatever `cap_ab_n` is, and `b_oe` becomes 0 whatever `drv_ab_n` is.
- R5: After a clock edge, `b_oe` is 1 exactly when `sel_ab_n`=0 and `drv_ab_n`=0 were sampled at that edge. While `b_oe` is 1, `b_out` equals the A-to-B bank contents.
- R6: The B-to-A direction obeys R2 to R5 with `sel_ba_n`, `cap_ba_n` and `drv_ba_n`, capturing `b_in` and presenting it on `a_out` / `a_oe`.
- R7: The controls of one direction never change the bank contents or the output enable of the other direction.
- R8: `contention` is 1 exactly when `a_oe` and `b_oe` are both 1.
- R9: Whenever an output enable is 0, the matching output vector is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | WIDTH | Value present on port A |
| a_out | output | WIDTH | Value port A should drive (B-to-A bank) |
| a_oe | output | 1 | Port A driver enable |
| b_in | input | WIDTH | Value present on port B |
| b_out | output | WIDTH | Value port B should drive (A-to-B bank) |
| b_oe | output | 1 | Port B driver enable |
| sel_ab_n | input | 1 | A-to-B select, active low |
| cap_ab_n | input | 1 | A-to-B capture, active low |
| drv_ab_n | input | 1 | A-to-B drive onto B, active low |
| sel_ba_n | input | 1 | B-to-A select, active low |
| cap_ba_n | input | 1 | B-to-A capture, active low |
| drv_ba_n | input | 1 | B-to-A drive onto A, active low |
| contention | output | 1 | Both ports driven at once |

## Verification
The bench targets the select override. It holds capture and drive low while the select is high, and a design that let capture or drive bypass the select would reload the bank or turn on the driver. It raises capture and then changes the source port. A bank that kept following would show the new value, not the frozen one. It also switches one direction's controls while the other direction holds a known value, so that any mixing between the banks shows up. Finally it enables both drivers together, and a missing or inverted `contention` flag would be reported.

// File: rtl/bilatch_xcvr_pkg.sv
// Shared types for the bidirectional latched transceiver.
// Assumes every control is active low and sampled on the rising clock edge.
package bilatch_xcvr_pkg;

    // Number of data directions: index 0 is A-to-B, index 1 is B-to-A.
    localparam int NUM_DIR = 2;
    localparam int DIR_AB  = 0;
    localparam int DIR_BA  = 1;

    // Control triple for one direction, all active low.
    typedef struct packed {
        logic sel_n;   // qualifies capture and drive
        logic cap_n;   // bank follows its source while low
        logic drv_n;   // bank drives the far port while low
    } dir_ctl_t;

endpackage

// File: rtl/bilatch_bank.sv
// One direction's storage bank and its output driver enable.
// While selected and capturing, the bank reloads from its source at every edge.
// The output vector reads as zero whenever the driver is off.
// Assumes: synchronous active-low reset; ctl is stable around the clock edge.
module bilatch_bank
    import bilatch_xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src,
    input  dir_ctl_t         ctl,
    output logic [WIDTH-1:0] dst,
    output logic             dst_oe
);

    logic [WIDTH-1:0] store_q;
    logic             oe_q;
    logic             load_en;
    logic             drive_en;

    // Decode the active-low controls; the select gates both actions.
    always_comb begin
        load_en  = !ctl.sel_n && !ctl.cap_n;
        drive_en = !ctl.sel_n && !ctl.drv_n;
    end

    // Storage: follow the source while loading, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (load_en) begin
            store_q <= src;
        end
    end

    // Register the driver enable so a port cannot glitch on between edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= drive_en;
        end
    end

    // Present stored data only while driving; quiet zeros otherwise.
    always_comb begin
        dst    = oe_q ? store_q : '0;
        dst_oe = oe_q;
    end

endmodule

// File: rtl/bilatch_clash.sv
// Contention monitor: flags when more than one direction drives at once.
// Assumes the enables come from registered drivers (no glitches).
module bilatch_clash #(
    parameter int NDIR = 2
) (
    input  logic [NDIR-1:0] oe_vec,
    output logic            clash
);

    // With two ports every direction drives a port the other one reads.
    always_comb begin
        clash = ($countones(oe_vec) > 1);
    end

endmodule

// File: rtl/bilatch_xcvr.sv
// Top level of the bidirectional latched transceiver core.
// Two banks share ports A and B in opposite directions. The pads' tri-state
// buffers live in the I/O ring and are steered by a_oe / b_oe.
// Assumes: single clock, synchronous active-low reset.
module bilatch_xcvr
    import bilatch_xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             sel_ab_n,
    input  logic             cap_ab_n,
    input  logic             drv_ab_n,
    input  logic             sel_ba_n,
    input  logic             cap_ba_n,
    input  logic             drv_ba_n,
    output logic             contention
);

    logic [WIDTH-1:0] src_arr [NUM_DIR];
    logic [WIDTH-1:0] dst_arr [NUM_DIR];
    dir_ctl_t         ctl_arr [NUM_DIR];
    logic [NUM_DIR-1:0] oe_vec;

    // Route each port and control triple to its direction's bank.
    always_comb begin
        src_arr[DIR_AB] = a_in;
        src_arr[DIR_BA] = b_in;
        ctl_arr[DIR_AB] = '{sel_n: sel_ab_n, cap_n: cap_ab_n, drv_n: drv_ab_n};
        ctl_arr[DIR_BA] = '{sel_n: sel_ba_n, cap_n: cap_ba_n, drv_n: drv_ba_n};
    end

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        bilatch_bank #(.WIDTH(WIDTH)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_arr[g]),
            .ctl    (ctl_arr[g]),
            .dst    (dst_arr[g]),
            .dst_oe (oe_vec[g])
        );
    end

    // The A-to-B bank feeds port B; the B-to-A bank feeds port A.
    always_comb begin
        b_out = dst_arr[DIR_AB];
        b_oe  = oe_vec[DIR_AB];
        a_out = dst_arr[DIR_BA];
        a_oe  = oe_vec[DIR_BA];
    end

    bilatch_clash #(.NDIR(NUM_DIR)) u_clash (
        .oe_vec (oe_vec),
        .clash  (contention)
    );

endmodule

// File: rtl/bilatch_xcvr_chk.sv
// Assertion checker for bilatch_xcvr, attached with bind below.
// Observes ports only; each property names the requirement it covers.
module bilatch_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             sel_ab_n,
    input logic             cap_ab_n,
    input logic             drv_ab_n,
    input logic             sel_ba_n,
    input logic             cap_ba_n,
    input logic             drv_ba_n,
    input logic             contention
);

    // R1: a reset edge leaves both drivers and the flag off.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!a_oe && !b_oe && !contention));

    // R2 and R5: selected, capturing and driving shows the sampled A input.
    a_r2_follow_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ab_n && !cap_ab_n && !drv_ab_n) |=> (b_oe && b_out == $past(a_in)));

    // R3: holding while driving keeps b_out steady.
    a_r3_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ab_n && !sel_ab_n && !drv_ab_n && b_oe) |=> $stable(b_out));

    // R4: a high select turns the B driver off whatever drive says.
    a_r4_sel_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ab_n |=> !b_oe);

    // R6: the mirror direction follows B onto A.
    a_r6_follow_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ba_n && !cap_ba_n && !drv_ba_n) |=> (a_oe && a_out == $past(b_in)));

    // R8: the flag marks exactly the cycles with both drivers on.
    a_r8_contention: assert property (@(posedge clk) disable iff (!rst_n)
        contention == (a_oe && b_oe));

    // R9: a disabled port presents zeros.
    a_r9_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_oe |-> a_out == '0) and (!b_oe |-> b_out == '0));

endmodule

bind bilatch_xcvr bilatch_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_in       (b_in),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .sel_ab_n   (sel_ab_n),
    .cap_ab_n   (cap_ab_n),
    .drv_ab_n   (drv_ab_n),
    .sel_ba_n   (sel_ba_n),
    .cap_ba_n   (cap_ba_n),
    .drv_ba_n   (drv_ba_n),
    .contention (contention)
);

// File: tb/bilatch_xcvr_bench.sv
// Self-checking bench: directed corner cases plus seeded random control mixes,
// compared against a bench-side model written from the requirements.
module bilatch_xcvr_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, contention;
    logic sel_ab_n = 1'b1, cap_ab_n = 1'b1, drv_ab_n = 1'b1;
    logic sel_ba_n = 1'b1, cap_ba_n = 1'b1, drv_ba_n = 1'b1;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic         m_boe = 1'b0, m_aoe = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bilatch_xcvr #(.WIDTH(W)) u_bilatch_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .sel_ab_n(sel_ab_n), .cap_ab_n(cap_ab_n), .drv_ab_n(drv_ab_n),
        .sel_ba_n(sel_ba_n), .cap_ba_n(cap_ba_n), .drv_ba_n(drv_ba_n),
        .contention(contention)
    );

    // Expected port value for a direction, zero while not driving.
    function automatic logic [W-1:0] exp_port(input logic oe, input logic [W-1:0] v);
        return oe ? v : '0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic check_all(input string tag);
        chk(tag, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, m_boe});
        chk(tag, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, m_aoe});
        chk(tag, "b_out", b_out, exp_port(m_boe, m_ab));
        chk(tag, "a_out", a_out, exp_port(m_aoe, m_ba));
        chk(tag, "contention(R8)", {{(W-1){1'b0}}, contention},
            {{(W-1){1'b0}}, m_aoe & m_boe});
    endtask

    // Drive one cycle at the falling edge, update model at the rising edge,
    // then compare at the next falling edge.
    task automatic cyc(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic [2:0] ab, input logic [2:0] ba, input string tag);
        @(negedge clk);
        a_in = av; b_in = bv;
        {sel_ab_n, cap_ab_n, drv_ab_n} = ab;
        {sel_ba_n, cap_ba_n, drv_ba_n} = ba;
        @(posedge clk);
        if (!rst_n) begin
            m_ab = '0; m_ba = '0; m_boe = 1'b0; m_aoe = 1'b0;
        end else begin
            if (!ab[2] && !ab[1]) m_ab = av;
            if (!ba[2] && !ba[1]) m_ba = bv;
            m_boe = !ab[2] && !ab[0];
            m_aoe = !ba[2] && !ba[0];
        end
        @(negedge clk);
        check_all(tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset with every control asserted still leaves all quiet.
        rst_n = 1'b0;
        cyc(8'hFF, 8'hFF, 3'b000, 3'b000, "R1");
        cyc(8'h11, 8'h22, 3'b000, 3'b000, "R1");
        rst_n = 1'b1;

        // R2/R5: capture and drive A to B.
        cyc(8'h5A, 8'h00, 3'b000, 3'b111, "R2");
        cyc(8'hC3, 8'h00, 3'b000, 3'b111, "R5");
        // R3: raise capture, then move the A input; B must keep C3.
        cyc(8'h0F, 8'h00, 3'b010, 3'b111, "R3");
        cyc(8'hF0, 8'h00, 3'b010, 3'b111, "R3");
        // R4: select high with capture and drive low: no load, driver off.
        cyc(8'h77, 8'h00, 3'b100, 3'b111, "R4");
        // R4 follow-up: re-enable drive only, stored value must still be C3.
        cyc(8'h99, 8'h00, 3'b010, 3'b111, "R4");
        // R9: drive off -> zeros on B.
        cyc(8'h99, 8'h00, 3'b011, 3'b111, "R9");

        // R6: B-to-A capture and drive, A-to-B held.
        cyc(8'h00, 8'hA5, 3'b111, 3'b000, "R6");
        cyc(8'h00, 8'h3C, 3'b111, 3'b010, "R6");
        // R7: toggle A-to-B capture hard; B-to-A bank and driver unchanged.
        cyc(8'hEE, 8'h44, 3'b001, 3'b010, "R7");
        cyc(8'hDD, 8'h55, 3'b000, 3'b010, "R7");
        // R8: both drivers on -> contention.
        cyc(8'h12, 8'h34, 3'b000, 3'b000, "R8");
        cyc(8'h12, 8'h34, 3'b010, 3'b011, "R8");

        // Random mixes across all requirements R2 to R9.
        for (int i = 0; i < 400; i++) begin
            cyc(8'($urandom), 8'($urandom), 3'($urandom), 3'($urandom), "R2-R9 random");
        end

        // R1: mid-run reset clears the banks.
        rst_n = 1'b0;
        cyc(8'hAB, 8'hCD, 3'b000, 3'b000, "R1");
        rst_n = 1'b1;
        cyc(8'hAB, 8'hCD, 3'b110, 3'b110, "R1");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule